// File: doc/BRIEF.md
# Core Test Wrapper Serial Controller

This block wraps an embedded core so that a tester can reach it over a single serial path. Inside the wrapper are three registers. A 3-bit instruction register has a shift stage and a separate active stage. A one-bit bypass register gives a short serial path. A boundary register is built from one cell on each functional input of the core and one cell on each functional output. All of them are clocked by the wrapper clock. Four strobes control them: one chooses between the instruction register and the data side, and the other three enable capture, shift and update on the chosen register.

The active instruction selects a mode. In normal mode (the bypass instruction) every cell passes its functional value straight through and the data side is the bypass bit. Under the external-test instruction, the output cells drive their update values onto the wrapper's output pins. Under the internal-test instruction, the input cells drive their update values into the core. The serial output is retimed on the falling clock edge so that several wrappers can be chained back to back.

Top module: `core_test_wrapper`

## Requirements
- R1: While the active-low reset `tw_rst_n` is low, the active instruction is bypass (3'b000), every cell passes its functional input straight through, and `ser_out` is 0.
- R2: With `sel_instr`=1 and `shift_en`=1, the instruction shift stage takes `ser_in` into bit 2 and moves toward bit 0, so the first bit shifted lands in bit 0. A shifted code takes effect only on a cycle with `sel_instr`=1 and `upd_en`=1. Codes: 3'b000 bypass, 3'b001 external test, 3'b010 internal test. Every other code acts as bypass.
- R3: With `sel_instr`=1 and `cap_en`=1, the instruction shift stage loads the active instruction. Shifting it out then presents bit 0 first on `ser_out`.
- R4: Under the bypass instruction, `core_in` equals `pin_in` and `pin_out` equals `core_out`.
- R5: Under the bypass instruction, with `sel_instr`=0, the bypass bit takes `ser_in` on a shift and 0 on a capture. It is the data-side serial source, so the delay from input to output is one clock.
- R6: Under the external-test or internal-test instruction, the data side is the boundary chain of length N_IN+N_OUT. The order from `ser_in` is input cells 0..N_IN-1, then output cells 0..N_OUT-1. The last output cell feeds `ser_out`.
- R7: A capture on the boundary chain loads each input cell from its `pin_in` bit and each output cell from its `core_out` bit. Capture takes priority over shift.
- R8: Under the external-test instruction, `pin_out` shows the output cells' update values and `core_in` still follows `pin_in`.
- R9: Under the internal-test instruction, `core_in` shows the input cells' update values and `pin_out` still follows `core_out`.
- R10: A cell's update value changes only on a cycle with `upd_en`=1, `sel_instr`=0 and the boundary chain selected. Shifting alone leaves `pin_out` and `core_in` unchanged.
- R11: `ser_out` changes only on the falling edge of `tw_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tw_clk | input | 1 | Wrapper clock |
| tw_rst_n | input | 1 | Asynchronous active-low reset to normal mode |
| ser_in | input | 1 | Serial test data in |
| sel_instr | input | 1 | 1 selects the instruction register, 0 the data side |
| cap_en | input | 1 | Capture strobe for the selected register |
| shift_en | input | 1 | Shift strobe for the selected register |
| upd_en | input | 1 | Update strobe for the selected register |
| ser_out | output | 1 | Serial test data out, retimed on the falling edge |
| pin_in | input | N_IN | Wrapper functional inputs from the chip |
| core_in | output | N_IN | Values presented to the core's inputs |
| core_out | input | N_OUT | The core's functional outputs |
| pin_out | output | N_OUT | Wrapper functional outputs to the chip |

## Verification
The bench targets the chain order. A design that reversed the order or skipped a cell would return the captured pin and core bits in the wrong order after a capture. It checks that a shifted instruction without an update changes nothing. A design that made the shift stage live would switch the output pins partway through a load. It also feeds an unused instruction code, which must fall back to pass-through rather than to a test mode. Finally, it samples `ser_out` between the rising and falling edges. A design that retimed the output on the rising edge would show the new bit half a cycle early.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b000;
    localparam logic [IR_W-1:0] OP_EXTEST = 3'b001;
    localparam logic [IR_W-1:0] OP_INTEST = 3'b010;

    typedef enum logic [1:0] {MODE_NORMAL, MODE_EXT, MODE_INT} tw_mode_e;

    function automatic tw_mode_e decode_op(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST: return MODE_EXT;
            OP_INTEST: return MODE_INT;
            default:   return MODE_NORMAL;
        endcase
    endfunction
endpackage

// File: rtl/tw_instr_reg.sv
`timescale 1ns/1ps
module tw_instr_reg
    import tw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  logic            sel,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    output logic [IR_W-1:0] op,
    output logic            tail
);
    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] act;
    } ir_state_t;

    ir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (cap)        st_d.sh = st_q.act;
            else if (shift) st_d.sh = {ser_in, st_q.sh[IR_W-1:1]};
            if (upd)        st_d.act = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '0, act: OP_BYPASS};
        else        st_q <= st_d;
    end

    assign op   = st_q.act;
    assign tail = st_q.sh[0];

    p_hold_without_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && upd) |=> $stable(op));
endmodule

// File: rtl/tw_bypass_bit.sv
`timescale 1ns/1ps
module tw_bypass_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    input  logic en,
    input  logic cap,
    input  logic shift,
    output logic q
);
    logic byp_d, byp_q;

    always_comb begin
        byp_d = byp_q;
        if (en) begin
            if (cap)        byp_d = 1'b0;
            else if (shift) byp_d = ser_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= byp_d;
    end

    assign q = byp_q;

    p_byp_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && shift && !cap) |=> (q == $past(ser_in)));
endmodule

// File: rtl/tw_bound_cell.sv
`timescale 1ns/1ps
module tw_bound_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic func_in,
    input  logic scan_in,
    input  logic cap,
    input  logic shift,
    input  logic upd,
    input  logic drive,
    output logic func_out,
    output logic scan_out
);
    typedef struct packed {
        logic cap_bit;
        logic upd_bit;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap)        st_d.cap_bit = func_in;
        else if (shift) st_d.cap_bit = scan_in;
        if (upd)        st_d.upd_bit = st_q.cap_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign func_out = drive ? st_q.upd_bit : func_in;
    assign scan_out = st_q.cap_bit;

    p_upd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.upd_bit));
endmodule

// File: rtl/core_test_wrapper.sv
`timescale 1ns/1ps
module core_test_wrapper
    import tw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             tw_clk,
    input  logic             tw_rst_n,
    input  logic             ser_in,
    input  logic             sel_instr,
    input  logic             cap_en,
    input  logic             shift_en,
    input  logic             upd_en,
    output logic             ser_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);
    localparam int CHAIN_LEN = N_IN + N_OUT;

    logic [IR_W-1:0]      op;
    logic                 ir_tail;
    tw_mode_e             mode;
    logic                 byp_sel, bnd_sel, byp_q;
    logic [CHAIN_LEN:0]   chain;
    logic [CHAIN_LEN-1:0] cell_fin, cell_fout;
    logic                 so_d, so_q;

    tw_instr_reg u_ir (
        .clk(tw_clk), .rst_n(tw_rst_n), .ser_in(ser_in), .sel(sel_instr),
        .cap(cap_en), .shift(shift_en), .upd(upd_en), .op(op), .tail(ir_tail)
    );

    assign mode    = decode_op(op);
    assign byp_sel = !sel_instr && (mode == MODE_NORMAL);
    assign bnd_sel = !sel_instr && (mode != MODE_NORMAL);

    tw_bypass_bit u_byp (
        .clk(tw_clk), .rst_n(tw_rst_n), .ser_in(ser_in), .en(byp_sel),
        .cap(cap_en), .shift(shift_en), .q(byp_q)
    );

    assign chain[0] = ser_in;
    assign cell_fin = {core_out, pin_in};

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
        logic drv;
        if (k < N_IN) begin : g_in_side
            assign drv = (mode == MODE_INT);
        end else begin : g_out_side
            assign drv = (mode == MODE_EXT);
        end
        tw_bound_cell u_cell (
            .clk(tw_clk), .rst_n(tw_rst_n), .func_in(cell_fin[k]),
            .scan_in(chain[k]), .cap(bnd_sel && cap_en),
            .shift(bnd_sel && shift_en), .upd(bnd_sel && upd_en),
            .drive(drv), .func_out(cell_fout[k]), .scan_out(chain[k+1])
        );
    end

    assign core_in = cell_fout[N_IN-1:0];
    assign pin_out = cell_fout[CHAIN_LEN-1:N_IN];

    always_comb begin
        if (sel_instr)    so_d = ir_tail;
        else if (bnd_sel) so_d = chain[CHAIN_LEN];
        else              so_d = byp_q;
    end

    always_ff @(negedge tw_clk or negedge tw_rst_n) begin
        if (!tw_rst_n) so_q <= 1'b0;
        else           so_q <= so_d;
    end

    assign ser_out = so_q;

    p_normal_pass_r4: assert property (@(posedge tw_clk) disable iff (!tw_rst_n)
        (op == OP_BYPASS) |-> (core_in == pin_in && pin_out == core_out));
    p_ext_core_side_r8: assert property (@(posedge tw_clk) disable iff (!tw_rst_n)
        (op == OP_EXTEST) |-> (core_in == pin_in));
    p_int_pin_side_r9: assert property (@(posedge tw_clk) disable iff (!tw_rst_n)
        (op == OP_INTEST) |-> (pin_out == core_out));
endmodule

// File: tb/core_test_wrapper_tb.sv
`timescale 1ns/1ps
module core_test_wrapper_tb;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int L  = NI + NO;

    logic tw_clk = 1'b0;
    logic tw_rst_n = 1'b0;
    logic ser_in = 1'b0, sel_instr = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0;
    logic ser_out;
    logic [NI-1:0] pin_in = '0, core_in;
    logic [NO-1:0] core_out = '0, pin_out;

    int checks = 0;
    int errors = 0;

    always #5 tw_clk = ~tw_clk;

    core_test_wrapper #(.N_IN(NI), .N_OUT(NO)) u_dut (
        .tw_clk(tw_clk), .tw_rst_n(tw_rst_n), .ser_in(ser_in), .sel_instr(sel_instr),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en), .ser_out(ser_out),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] ld;
        logic [3:0] pi;
        logic [3:0] co;
        logic [3:0] ecin;
        logic [3:0] epout;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{3'b000, 8'hA5, 4'h3, 4'hC, 4'h3, 4'hC},   // R4 bypass pass-through
        '{3'b001, 8'hA5, 4'h3, 4'hC, 4'h3, 4'hA},   // R8 external drives pins
        '{3'b010, 8'h5A, 4'h3, 4'hC, 4'hA, 4'hC},   // R9 internal drives core
        '{3'b111, 8'hFF, 4'h6, 4'h9, 4'h6, 4'h9},   // R2 unused code acts as bypass
        '{3'b001, 8'h3C, 4'hF, 4'h0, 4'hF, 4'h3}    // R8 second pattern
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tw_clk);
        @(negedge tw_clk);
        #1;
    endtask

    task automatic load_instr(input logic [2:0] code);
        sel_instr = 1'b1; shift_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            ser_in = code[i];
            tick();
        end
        shift_en = 1'b0; upd_en = 1'b1;
        tick();
        upd_en = 1'b0; sel_instr = 1'b0;
    endtask

    task automatic shift_dr(input logic [7:0] v);
        sel_instr = 1'b0; shift_en = 1'b1;
        for (int i = L - 1; i >= 0; i--) begin
            ser_in = v[i];
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic update_dr();
        sel_instr = 1'b0; upd_en = 1'b1;
        tick();
        upd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        pin_in = 4'h5; core_out = 4'hA;
        #12;
        check("R1 reset core_in", {4'h0, core_in}, 8'h05);
        check("R1 reset pin_out", {4'h0, pin_out}, 8'h0A);
        check("R1 reset ser_out", {7'h0, ser_out}, 8'h00);
        tw_rst_n = 1'b1;
        @(negedge tw_clk); #1;

        for (int v = 0; v < 5; v++) begin
            pin_in = VEC[v].pi; core_out = VEC[v].co;
            load_instr(VEC[v].op);
            shift_dr(VEC[v].ld);
            update_dr();
            check($sformatf("R4/R8/R9 vec%0d core_in", v), {4'h0, core_in}, {4'h0, VEC[v].ecin});
            check($sformatf("R4/R8/R9 vec%0d pin_out", v), {4'h0, pin_out}, {4'h0, VEC[v].epout});
        end

        // R6 R7: capture pins and core outputs, read chain out last cell first
        load_instr(3'b001);
        pin_in = 4'h9; core_out = 4'h6;
        sel_instr = 1'b0; cap_en = 1'b1; shift_en = 1'b1;
        tick();
        cap_en = 1'b0;
        got = {7'h0, ser_out};
        for (int i = 1; i < L; i++) begin
            ser_in = 1'b0;
            tick();
            got = {got[6:0], ser_out};
        end
        shift_en = 1'b0;
        check("R6 R7 captured chain", got, 8'h69);

        // R10: shifting without update leaves pins alone
        shift_dr(8'h50);
        update_dr();
        check("R10 pin_out after update", {4'h0, pin_out}, 8'h05);
        shift_dr(8'hA0);
        check("R10 pin_out held during shift", {4'h0, pin_out}, 8'h05);
        update_dr();
        check("R10 pin_out after second update", {4'h0, pin_out}, 8'h0A);

        // R2: shifted code without update has no effect
        sel_instr = 1'b1; shift_en = 1'b1;
        ser_in = 1'b0; tick();
        ser_in = 1'b1; tick();
        ser_in = 1'b0; tick();
        shift_en = 1'b0;
        check("R2 no update keeps external", {4'h0, pin_out}, 8'h0A);

        // R3: capture active instruction, read bit0 first
        cap_en = 1'b1; tick(); cap_en = 1'b0;
        got = {7'h0, ser_out};
        shift_en = 1'b1;
        tick(); got = {got[6:0], ser_out};
        tick(); got = {got[6:0], ser_out};
        shift_en = 1'b0; sel_instr = 1'b0;
        check("R3 readback bit order", got, 8'b100);

        // R1: reset mid-run returns to pass-through
        core_out = 4'h3;
        tw_rst_n = 1'b0; #2;
        check("R1 async reset pin_out", {4'h0, pin_out}, 8'h03);
        @(negedge tw_clk); tw_rst_n = 1'b1; #1;

        // R5: bypass one-cycle path and capture of zero
        shift_en = 1'b1; ser_in = 1'b1; tick();
        check("R5 bypass shift one", {7'h0, ser_out}, 8'h01);
        ser_in = 1'b0; tick();
        check("R5 bypass shift zero", {7'h0, ser_out}, 8'h00);
        ser_in = 1'b1; tick();
        shift_en = 1'b0; cap_en = 1'b1; tick(); cap_en = 1'b0;
        check("R5 bypass capture zero", {7'h0, ser_out}, 8'h00);

        // R11: output moves on the falling edge only
        shift_en = 1'b1; ser_in = 1'b1;
        @(posedge tw_clk); #1;
        check("R11 ser_out before falling edge", {7'h0, ser_out}, 8'h00);
        @(negedge tw_clk); #1;
        check("R11 ser_out after falling edge", {7'h0, ser_out}, 8'h01);
        shift_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule